// File: doc/BRIEF.md
# Temperature-Indexed Duty-Cycle Trim Controller

This block closes the bias-correction loop around an oscillator-based random bit source. The bit source samples a fast oscillator on the edges of a jittery slow clock. The chance of a '1' follows the fast oscillator's duty cycle. A time-to-digital monitor turns that duty cycle into a count once per slow cycle. A larger count means a longer high phase.

On each new count, the controller looks up a target count for the present temperature. The targets come from a small calibration table that is loaded beforehand. The controller then moves a 4-bit fine trim word one step so that the count moves toward the target. The fine trim drives the rise-edge delay of a programmable delay cell. A larger code gives a shorter rise delay and a higher duty cycle, so a count above the target lowers the code. A coarse trim word is loaded once by configuration to cancel the process offset. The loop never alters it.

The block also thins the sampled bit stream to half rate. The first accepted bit is kept, the next is dropped, and so on. The bit stream uses valid/ready on both sides. On a keep phase, the input ready follows the output ready, so back-pressure reaches the bit source and no kept bit is lost. On a drop phase, the input is always ready and the output shows no valid.

Top module: `dcc_ctrl`

## Requirements
- R1: After reset, fine_trim is 8, coarse_trim is 8, every table entry holds target 32, and the first accepted raw bit lands in the keep phase.
- R2: When est_valid is high, load_en is low, and est_count exceeds the target by more than deadband, fine_trim decreases by one on the next clock edge.
- R3: When est_valid is high, load_en is low, and the target exceeds est_count by more than deadband, fine_trim increases by one on the next clock edge.
- R4: When the absolute difference between est_count and the target is at or below deadband, fine_trim is held.
- R5: fine_trim saturates. It stays at 0 on a further decrement and at 15 on a further increment, and never wraps.
- R6: The target is the table entry selected by temp[7:4], which gives 16 bins of 16 temperature codes each.
- R7: A table write (tbl_we with tbl_addr and tbl_data) takes effect only while load_en is high. While load_en is high, fine_trim does not change whatever est_valid does.
- R8: coarse_trim takes coarse_data on a clock edge with coarse_we high. It changes at no other time and is unaffected by the loop.
- R9: Accepted raw bits alternate between keep and drop, starting with keep. A kept bit appears on rnd_bit with rnd_valid high. A dropped bit raises no rnd_valid.
- R10: In the keep phase, raw_ready equals rnd_ready. A stalled kept bit is held, and the phase does not advance until it is accepted. In the drop phase, raw_ready is 1.
- R11: Without est_valid, fine_trim does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Calibration mode: enables table writes and freezes the loop |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table bin to write |
| tbl_data | input | 6 | Target count to write |
| coarse_we | input | 1 | Coarse trim load strobe |
| coarse_data | input | 4 | Coarse trim value |
| temp | input | 8 | Temperature reading from the sensor |
| deadband | input | 6 | Hold window on the count error |
| est_valid | input | 1 | A new duty-cycle count is present |
| est_count | input | 6 | Duty-cycle count, 0 to 63 |
| fine_trim | output | 4 | Fine rise-delay trim code |
| coarse_trim | output | 4 | Coarse rise-delay trim code |
| raw_valid | input | 1 | Sampled bit valid |
| raw_ready | output | 1 | Sampled bit accepted |
| raw_bit | input | 1 | Sampled random bit |
| rnd_valid | output | 1 | Decimated bit valid |
| rnd_ready | input | 1 | Downstream ready |
| rnd_bit | output | 1 | Decimated random bit |

## Verification
The bench builds the block with its default parameters: a 6-bit count, 8-bit temperature, 16 bins and a 4-bit trim. With a 4-bit trim, both saturation rails are reached within 16 updates, so driving the loop into 0 and 15 is a short directed sequence. With 16 bins, the bench can write one bin, then steer between that bin and an untouched one by changing only the upper temperature nibble. That shows which entry is selected. The bench also writes the table while load_en is low and confirms the old target still rules. On the bit path, the bench stalls the output on a keep phase and shows that the same bit stays presented and the drop phase waits.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  typedef enum logic {
    PH_KEEP = 1'b0,
    PH_DROP = 1'b1
  } phase_e;
endpackage

// File: rtl/dcc_target_table.sv
module dcc_target_table #(
  parameter int CNT_W  = 6,
  parameter int BIN_W  = 4,
  parameter int RST_TGT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BIN_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NBINS = 1 << BIN_W;

  logic [CNT_W-1:0] entry [NBINS];

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[b] <= CNT_W'(RST_TGT);
      else if (wr_en && (wr_addr == BIN_W'(b)))
        entry[b] <= wr_data;
    end
  end

  assign rd_data = entry[rd_addr];
endmodule

// File: rtl/dcc_trim_stepper.sv
module dcc_trim_stepper
  import dcc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int TRIM_W   = 4,
  parameter int RST_TRIM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  target,
  input  logic [CNT_W-1:0]  deadband,
  output logic [TRIM_W-1:0] trim
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  logic [CNT_W:0] err_mag;
  step_e          dir;

  always_comb begin
    if (count >= target)
      err_mag = {1'b0, count} - {1'b0, target};
    else
      err_mag = {1'b0, target} - {1'b0, count};

    if (err_mag <= {1'b0, deadband})
      dir = STEP_HOLD;
    else if (count > target)
      dir = STEP_DOWN;
    else
      dir = STEP_UP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trim <= TRIM_W'(RST_TRIM);
    else if (upd_en) begin
      unique case (dir)
        STEP_UP:   if (trim != TRIM_MAX)      trim <= trim + 1'b1;
        STEP_DOWN: if (trim != '0)            trim <= trim - 1'b1;
        default:   trim <= trim;
      endcase
    end
  end
endmodule

// File: rtl/dcc_decimator.sv
module dcc_decimator
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  phase_e phase;

  assign out_valid = in_valid && (phase == PH_KEEP);
  assign out_bit   = in_bit;
  assign in_ready  = (phase == PH_KEEP) ? out_ready : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= PH_KEEP;
    else if (in_valid && in_ready)
      phase <= (phase == PH_KEEP) ? PH_DROP : PH_KEEP;
  end
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl #(
  parameter int CNT_W      = 6,
  parameter int TEMP_W     = 8,
  parameter int BIN_W      = 4,
  parameter int TRIM_W     = 4,
  parameter int RST_TRIM   = 8,
  parameter int RST_COARSE = 8,
  parameter int RST_TGT    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              tbl_we,
  input  logic [BIN_W-1:0]  tbl_addr,
  input  logic [CNT_W-1:0]  tbl_data,
  input  logic              coarse_we,
  input  logic [TRIM_W-1:0] coarse_data,
  input  logic [TEMP_W-1:0] temp,
  input  logic [CNT_W-1:0]  deadband,
  input  logic              est_valid,
  input  logic [CNT_W-1:0]  est_count,
  output logic [TRIM_W-1:0] fine_trim,
  output logic [TRIM_W-1:0] coarse_trim,
  input  logic              raw_valid,
  output logic              raw_ready,
  input  logic              raw_bit,
  output logic              rnd_valid,
  input  logic              rnd_ready,
  output logic              rnd_bit
);
  localparam int BIN_LSB = TEMP_W - BIN_W;

  logic [BIN_W-1:0] bin_sel;
  logic [CNT_W-1:0] target;

  assign bin_sel = temp[TEMP_W-1:BIN_LSB];

  dcc_target_table #(
    .CNT_W(CNT_W), .BIN_W(BIN_W), .RST_TGT(RST_TGT)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we && load_en), .wr_addr(tbl_addr), .wr_data(tbl_data),
    .rd_addr(bin_sel), .rd_data(target)
  );

  dcc_trim_stepper #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .RST_TRIM(RST_TRIM)
  ) u_step (
    .clk(clk), .rst_n(rst_n),
    .upd_en(est_valid && !load_en),
    .count(est_count), .target(target), .deadband(deadband),
    .trim(fine_trim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      coarse_trim <= TRIM_W'(RST_COARSE);
    else if (coarse_we)
      coarse_trim <= coarse_data;
  end

  dcc_decimator u_dec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(raw_valid), .in_ready(raw_ready), .in_bit(raw_bit),
    .out_valid(rnd_valid), .out_ready(rnd_ready), .out_bit(rnd_bit)
  );
endmodule

// File: rtl/dcc_ctrl_checker.sv
module dcc_ctrl_checker #(
  parameter int CNT_W  = 6,
  parameter int TRIM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic              coarse_we,
  input logic              est_valid,
  input logic [TRIM_W-1:0] fine_trim,
  input logic [TRIM_W-1:0] coarse_trim,
  input logic              raw_valid,
  input logic              raw_ready,
  input logic              rnd_valid,
  input logic              rnd_ready
);
  localparam logic [TRIM_W-1:0] TMAX = {TRIM_W{1'b1}};

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fine_trim) |-> (fine_trim == $past(fine_trim) + 1'b1) || (fine_trim == $past(fine_trim) - 1'b1)); // R2
  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fine_trim) == '0) |-> (fine_trim != TMAX)); // R5
  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fine_trim) == TMAX) |-> (fine_trim != '0)); // R5
  AST_LOAD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> $stable(fine_trim)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !est_valid |=> $stable(fine_trim)); // R11
  AST_COARSE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_we |=> $stable(coarse_trim)); // R8
  AST_DROP_AFTER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && rnd_ready) |=> !rnd_valid); // R9
  AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> raw_valid); // R9
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && !rnd_ready) |-> !raw_ready); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && !rnd_ready && raw_valid) |=> (raw_valid -> rnd_valid)); // R10
endmodule

bind dcc_ctrl dcc_ctrl_checker #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .coarse_we(coarse_we),
  .est_valid(est_valid), .fine_trim(fine_trim), .coarse_trim(coarse_trim),
  .raw_valid(raw_valid), .raw_ready(raw_ready),
  .rnd_valid(rnd_valid), .rnd_ready(rnd_ready)
);

// File: tb/sim_dcc_ctrl.sv
`timescale 1ns/1ps
module sim_dcc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 0, tbl_we = 0, coarse_we = 0, est_valid = 0;
  logic [3:0] tbl_addr = 0, coarse_data = 0;
  logic [5:0] tbl_data = 0, deadband = 0, est_count = 0;
  logic [7:0] temp = 0;
  logic [3:0] fine_trim, coarse_trim;
  logic       raw_valid = 0, raw_bit = 0, rnd_ready = 1;
  logic       raw_ready, rnd_valid, rnd_bit;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dcc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .coarse_we(coarse_we),
    .coarse_data(coarse_data), .temp(temp), .deadband(deadband),
    .est_valid(est_valid), .est_count(est_count), .fine_trim(fine_trim),
    .coarse_trim(coarse_trim), .raw_valid(raw_valid), .raw_ready(raw_ready),
    .raw_bit(raw_bit), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
    .rnd_bit(rnd_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_est(input logic [5:0] c);
    est_count = c;
    est_valid = 1;
    tick();
    est_valid = 0;
  endtask

  task automatic write_bin(input logic [3:0] a, input logic [5:0] d, input logic with_load);
    load_en = with_load;
    tbl_addr = a;
    tbl_data = d;
    tbl_we = 1;
    tick();
    tbl_we = 0;
    load_en = 0;
  endtask

  task automatic t_reset();
    check("R1 fine reset", fine_trim, 8);
    check("R1 coarse reset", coarse_trim, 8);
    check("R1 keep phase at start", raw_ready, 1);
    temp = 8'h00;
    deadband = 0;
    apply_est(6'd32);
    check("R1 reset target 32 holds", fine_trim, 8);
  endtask

  task automatic t_steps();
    write_bin(4'd3, 6'd20, 1'b1);
    temp = 8'h35;
    deadband = 0;
    apply_est(6'd25);
    check("R2 step down", fine_trim, 7);
    apply_est(6'd10);
    check("R3 step up", fine_trim, 8);
    apply_est(6'd20);
    check("R4 equal holds", fine_trim, 8);
    deadband = 5;
    apply_est(6'd25);
    check("R4 inside deadband holds", fine_trim, 8);
    apply_est(6'd15);
    check("R4 lower deadband edge holds", fine_trim, 8);
    apply_est(6'd26);
    check("R2 outside deadband steps", fine_trim, 7);
    apply_est(6'd14);
    check("R3 outside deadband steps", fine_trim, 8);
    deadband = 0;
    est_count = 6'd63;
    tick();
    tick();
    check("R11 no est_valid holds", fine_trim, 8);
  endtask

  task automatic t_bins();
    temp = 8'h0F;
    apply_est(6'd40);
    check("R6 bin0 target 32", fine_trim, 7);
    temp = 8'h30;
    apply_est(6'd19);
    check("R6 bin3 target 20", fine_trim, 8);
  endtask

  task automatic t_saturate();
    temp = 8'h30;
    for (int i = 0; i < 12; i++) apply_est(6'd63);
    check("R5 low rail", fine_trim, 0);
    apply_est(6'd63);
    check("R5 no wrap at 0", fine_trim, 0);
    for (int i = 0; i < 18; i++) apply_est(6'd0);
    check("R5 high rail", fine_trim, 15);
    apply_est(6'd0);
    check("R5 no wrap at 15", fine_trim, 15);
  endtask

  task automatic t_load();
    write_bin(4'd3, 6'd60, 1'b0);
    temp = 8'h30;
    apply_est(6'd25);
    check("R7 write without load ignored", fine_trim, 14);
    load_en = 1;
    est_count = 6'd63;
    est_valid = 1;
    tick();
    tick();
    est_valid = 0;
    load_en = 0;
    check("R7 load freezes loop", fine_trim, 14);
  endtask

  task automatic t_coarse();
    coarse_data = 4'd5;
    coarse_we = 1;
    tick();
    coarse_we = 0;
    check("R8 coarse load", coarse_trim, 5);
    coarse_data = 4'd11;
    apply_est(6'd63);
    apply_est(6'd0);
    check("R8 coarse untouched by loop", coarse_trim, 5);
  endtask

  task automatic t_decimate();
    rnd_ready = 1;
    raw_valid = 1;
    raw_bit = 1;
    #1;
    check("R9 keep valid", rnd_valid, 1);
    check("R9 keep bit", rnd_bit, 1);
    tick();
    raw_bit = 0;
    #1;
    check("R9 drop no valid", rnd_valid, 0);
    check("R10 drop phase ready", raw_ready, 1);
    tick();
    raw_bit = 0;
    rnd_ready = 0;
    #1;
    check("R10 keep phase stalls ready", raw_ready, 0);
    check("R9 kept bit 0", rnd_bit, 0);
    tick();
    check("R10 stalled bit still valid", rnd_valid, 1);
    rnd_ready = 1;
    #1;
    check("R10 ready follows output", raw_ready, 1);
    tick();
    check("R9 drop after accept", rnd_valid, 0);
    raw_valid = 0;
    tick();
    check("R9 idle drop phase held", rnd_valid, 0);
    raw_valid = 1;
    tick();
    raw_valid = 0;
    #1;
    check("R9 keep phase returns", raw_ready, 1);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_steps();
    t_bins();
    t_saturate();
    t_load();
    t_coarse();
    t_decimate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule